// File: doc/BRIEF.md
# SPI Master Byte Transfer Engine

This block is the serial core of an SPI master. Software sets the clock polarity, clock phase, bit order and chip-select routing, and loads a burst length in bytes. A one-cycle start strobe then sets an internal start flag. The engine takes bytes from a transmit FIFO and shifts them out on MOSI. At the same time it shifts MISO into a receive register and pushes each completed byte into a receive FIFO. When the last byte is done the start flag clears itself and a one-cycle completion pulse appears. The serial clock rate comes from an external divider, which supplies a tick once per SCLK half-period.

A state machine in the top module controls the sequence. It has five states:
- `S_IDLE`: waits for start.
- `S_LOAD`: pops the next transmit byte. It stays here while the transmit FIFO is empty.
- `S_SHIFT`: makes one SCLK edge per tick, 2×DATA_W edges per byte.
- `S_TRAIL`: holds the chip select for one more tick after the last edge.
- `S_DONE`: a single cycle that raises the completion pulse.

The transitions are as follows:
- start with a non-zero length goes from IDLE to LOAD.
- start with a zero length goes from IDLE to DONE.
- a popped byte goes from LOAD to SHIFT.
- the final edge of a byte goes from SHIFT to LOAD if bytes remain, or to TRAIL on the last byte.
- a tick goes from TRAIL to DONE.
- DONE always goes to IDLE.
- losing the run condition sends any state to IDLE.

A bit-shifter submodule holds the transmit and receive shift registers. A decoder submodule drives the chip-select lines.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset all ss_n lines are high and sclk equals cpol. busy, done, tx_pop and rx_push are all 0.
- R2: A start_wr pulse needs run_en=1, master_en=1 and soft_rst=0 together with burst_len=N>0. It sets busy from the next cycle and transfers exactly N bytes, popping one transmit byte per byte sent. A start_wr while run_en=0 is ignored: busy stays 0, nothing is popped and ss_n stays high.
- R3: sclk rests at the cpol level whenever no edge is in progress. cpol=1 means the clock idles high.
- R4: When cpha=0, each bit is on MOSI before its leading edge. Both sides sample on leading edges and change data on trailing edges. When cpha=1, data changes on leading edges and is sampled on trailing edges. A leading edge is one that moves sclk away from cpol.
- R5: When lsb_first=1, bit 0 of each byte goes out first and is received first. When lsb_first=0, bit DATA_W-1 goes first.
- R6: After the final edge of each byte, rx_push is high for one cycle. At that moment rx_data holds the DATA_W bits sampled from MISO in the selected bit order.
- R7: When cs_sw=0, line ss_n[cs_sel] is low from the cycle after start until the completion pulse, and it is already low before the first SCLK edge. The value k on cs_sel selects ss_n[k]. All other lines stay high.
- R8: When cs_sw=1, ss_n[cs_sel] equals cs_level (1 = high) whatever the transfer is doing, and the other lines stay high.
- R9: While the transmit FIFO is empty and bytes remain, no SCLK edge is produced and nothing is popped. Shifting resumes once a byte is available.
- R10: After the last edge the engine waits one tick. Then, in a single cycle, busy clears, ss_n rises and done is high. done never lasts more than one cycle.
- R11: If soft_rst is raised, or run_en or master_en is lowered, during a burst, the engine is idle on the next cycle: busy=0, sclk=cpol, ss_n high, and no done.
- R12: A start_wr with burst_len=0 produces done in the following cycle, with no SCLK edge and no pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk_tick | input | 1 | One pulse per SCLK half-period from the external divider |
| run_en | input | 1 | Global enable |
| master_en | input | 1 | Master-mode select; must be 1 to run |
| soft_rst | input | 1 | Forces the engine to idle while high |
| start_wr | input | 1 | One-cycle strobe that sets the start flag |
| cpol | input | 1 | Clock idle level |
| cpha | input | 1 | Clock phase select |
| lsb_first | input | 1 | Bit order: 1 = LSB first |
| cs_sel | input | 2 | Index of the chip-select line to drive |
| cs_sw | input | 1 | 1 = chip select driven by cs_level |
| cs_level | input | 1 | Software chip-select level |
| burst_len | input | 16 | Bytes in the burst, sampled at start |
| tx_empty | input | 1 | Transmit FIFO empty |
| tx_data | input | 8 | Transmit FIFO head byte |
| tx_pop | output | 1 | Pops the transmit FIFO head |
| rx_push | output | 1 | Pushes rx_data into the receive FIFO |
| rx_data | output | 8 | Received byte |
| miso | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| ss_n | output | 4 | Active-low chip selects |
| busy | output | 1 | Start flag readback |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench includes a slave model that decodes SCLK edges. It checks that the sample and change edges match each phase and polarity. A wrong phase would shift every received byte by one bit, and a wrong bit order would mirror the bytes. The bench also covers the following corner cases:
- A transmit FIFO that runs dry in the middle of a burst must freeze SCLK. A design that shifted anyway would send stale data and produce extra edges.
- Soft reset in the middle of a burst must not raise done.
- A zero-length start must complete without any SCLK or chip-select activity.
- In software chip-select mode, a design that let the transfer move the line would be seen low during the burst.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
    typedef enum logic [2:0] {
        S_IDLE,
        S_LOAD,
        S_SHIFT,
        S_TRAIL,
        S_DONE
    } eng_state_t;
endpackage

// File: rtl/spi_bit_shifter.sv
module spi_bit_shifter #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              load,
    input  logic [DATA_W-1:0] load_byte,
    input  logic              shift_out,
    input  logic              sample_in,
    input  logic              lsb_first,
    input  logic              miso,
    output logic              mosi,
    output logic [DATA_W-1:0] rx_byte
);
    logic [DATA_W-1:0] tx_sr;
    logic [DATA_W-1:0] rx_sr;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_sr <= '0;
        end else if (clr) begin
            tx_sr <= '0;
        end else if (load) begin
            tx_sr <= load_byte;
        end else if (shift_out) begin
            tx_sr <= lsb_first ? (tx_sr >> 1) : (tx_sr << 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_sr <= '0;
        end else if (clr) begin
            rx_sr <= '0;
        end else if (sample_in) begin
            rx_sr <= lsb_first ? {miso, rx_sr[DATA_W-1:1]} : {rx_sr[DATA_W-2:0], miso};
        end
    end

    assign mosi    = lsb_first ? tx_sr[0] : tx_sr[DATA_W-1];
    assign rx_byte = rx_sr;

    // R4
    load_shift_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(load && shift_out));
endmodule

// File: rtl/spi_cs_decode.sv
module spi_cs_decode #(
    parameter int NUM_CS = 4,
    localparam int SEL_W = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic [SEL_W-1:0]  sel,
    input  logic              sw_own,
    input  logic              sw_level,
    input  logic              hw_active,
    output logic [NUM_CS-1:0] ss_n
);
    for (genvar g = 0; g < NUM_CS; g++) begin : g_line
        always_comb begin
            if (sel != SEL_W'(g)) begin
                ss_n[g] = 1'b1;
            end else if (sw_own) begin
                ss_n[g] = sw_level;
            end else begin
                ss_n[g] = ~hw_active;
            end
        end
    end
endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_eng_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int LEN_W  = 16,
    parameter int NUM_CS = 4,
    localparam int SEL_W  = (NUM_CS > 1) ? $clog2(NUM_CS) : 1,
    localparam int EDGES  = 2 * DATA_W,
    localparam int EDGE_W = $clog2(EDGES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_tick,
    input  logic              run_en,
    input  logic              master_en,
    input  logic              soft_rst,
    input  logic              start_wr,
    input  logic              cpol,
    input  logic              cpha,
    input  logic              lsb_first,
    input  logic [SEL_W-1:0]  cs_sel,
    input  logic              cs_sw,
    input  logic              cs_level,
    input  logic [LEN_W-1:0]  burst_len,
    input  logic              tx_empty,
    input  logic [DATA_W-1:0] tx_data,
    output logic              tx_pop,
    output logic              rx_push,
    output logic [DATA_W-1:0] rx_data,
    input  logic              miso,
    output logic              sclk,
    output logic              mosi,
    output logic [NUM_CS-1:0] ss_n,
    output logic              busy,
    output logic              done
);
    eng_state_t        st, nx;
    logic              run_ok;
    logic [LEN_W-1:0]  cnt;
    logic [EDGE_W-1:0] ecnt;
    logic [EDGE_W-1:0] k;
    logic              ph;
    logic              push_q;
    logic              edge_now;
    logic              last_edge;
    logic              shift_out;
    logic              sample_in;

    assign run_ok    = run_en && master_en && !soft_rst;
    assign k         = ecnt + EDGE_W'(1);
    assign edge_now  = (st == S_SHIFT) && sclk_tick;
    assign last_edge = edge_now && (k == EDGE_W'(EDGES));

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= S_IDLE;
        else        st <= nx;
    end

    // Next-state logic
    always_comb begin
        nx = st;
        unique case (st)
            S_IDLE:  if (start_wr) nx = (burst_len == '0) ? S_DONE : S_LOAD;
            S_LOAD:  if (!tx_empty) nx = S_SHIFT;
            S_SHIFT: if (last_edge) nx = (cnt == LEN_W'(1)) ? S_TRAIL : S_LOAD;
            S_TRAIL: if (sclk_tick) nx = S_DONE;
            S_DONE:  nx = S_IDLE;
            default: nx = S_IDLE;
        endcase
        if (!run_ok) nx = S_IDLE;
    end

    // Burst and edge counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt    <= '0;
            ecnt   <= '0;
            ph     <= 1'b0;
            push_q <= 1'b0;
        end else if (!run_ok) begin
            ecnt   <= '0;
            ph     <= 1'b0;
            push_q <= 1'b0;
        end else begin
            push_q <= last_edge;
            if (st == S_IDLE && start_wr) cnt <= burst_len;
            if (st == S_LOAD) begin
                ecnt <= '0;
                ph   <= 1'b0;
            end else if (edge_now) begin
                ecnt <= k;
                ph   <= ~ph;
                if (last_edge) cnt <= cnt - LEN_W'(1);
            end
        end
    end

    // Outputs
    always_comb begin
        tx_pop    = (st == S_LOAD) && !tx_empty && run_ok;
        busy      = (st == S_LOAD) || (st == S_SHIFT) || (st == S_TRAIL);
        done      = (st == S_DONE);
        sclk      = cpol ^ ph;
        rx_push   = push_q;
        shift_out = 1'b0;
        sample_in = 1'b0;
        if (edge_now && run_ok) begin
            if (cpha) begin
                sample_in = !k[0];
                shift_out = k[0] && (k != EDGE_W'(1));
            end else begin
                sample_in = k[0];
                shift_out = !k[0] && (k != EDGE_W'(EDGES));
            end
        end
    end

    spi_bit_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (!run_ok),
        .load      (tx_pop),
        .load_byte (tx_data),
        .shift_out (shift_out),
        .sample_in (sample_in),
        .lsb_first (lsb_first),
        .miso      (miso),
        .mosi      (mosi),
        .rx_byte   (rx_data)
    );

    spi_cs_decode #(.NUM_CS(NUM_CS)) u_cs (
        .sel       (cs_sel),
        .sw_own    (cs_sw),
        .sw_level  (cs_level),
        .hw_active (busy),
        .ss_n      (ss_n)
    );

    // R10
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R10
    busy_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (done || $past(!run_ok)));
    // R9
    sclk_only_shift_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (run_ok && $changed(sclk) && $stable(cpol)) |-> $past(st == S_SHIFT));
    // R6
    rx_push_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_push |=> !rx_push);
    // R7
    ss_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~ss_n));
    // R11
    abort_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !run_ok |=> !busy);
endmodule

// File: tb/tb_spi_xfer_engine.sv
`timescale 1ns/100ps
module tb_spi_xfer_engine;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic       sclk_tick, run_en, master_en, soft_rst, start_wr;
    logic       cpol, cpha, lsb_first, cs_sw, cs_level, miso;
    logic [1:0] cs_sel;
    logic [15:0] burst_len;
    logic       tx_empty, tx_pop, rx_push, sclk, mosi, busy, done;
    logic [7:0] tx_data, rx_data;
    logic [3:0] ss_n;

    spi_xfer_engine dut (
        .clk(clk), .rst_n(rst_n), .sclk_tick(sclk_tick), .run_en(run_en),
        .master_en(master_en), .soft_rst(soft_rst), .start_wr(start_wr),
        .cpol(cpol), .cpha(cpha), .lsb_first(lsb_first), .cs_sel(cs_sel),
        .cs_sw(cs_sw), .cs_level(cs_level), .burst_len(burst_len),
        .tx_empty(tx_empty), .tx_data(tx_data), .tx_pop(tx_pop),
        .rx_push(rx_push), .rx_data(rx_data), .miso(miso), .sclk(sclk),
        .mosi(mosi), .ss_n(ss_n), .busy(busy), .done(done)
    );

    int n_chk = 0;
    int n_fail = 0;
    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // tick divider: one tick every 4 cycles
    logic [1:0] tdiv = '0;
    always @(negedge clk) tdiv <= tdiv + 2'd1;
    assign sclk_tick = (tdiv == 2'd0);

    // transmit FIFO model
    logic [7:0] tx_mem [0:15];
    int tx_rd = 0;
    int tx_avail = 0;
    logic fifo_clr = 1'b0;
    always @(posedge clk) begin
        if (fifo_clr) tx_rd <= 0;
        else if (tx_pop) tx_rd <= tx_rd + 1;
    end
    assign tx_empty = (tx_rd >= tx_avail);
    assign tx_data  = tx_mem[tx_rd[3:0]];

    logic [7:0] cur_seed = '0;
    function automatic logic [7:0] tx_byte(input int i);
        return 8'((cur_seed ^ 8'(i * 53)) + i);
    endfunction
    function automatic logic [7:0] sl_byte(input int i);
        return 8'(~cur_seed + 8'(i * 75));
    endfunction

    // slave model and monitor
    int e = 0, bi = 0, rxi = 0, edges = 0, done_cnt = 0, ss_bad = 0;
    logic done_ss_ok = 1'b0;
    logic sclk_prev = 1'b0, ss_lo_prev = 1'b0, mon_clr = 1'b0;
    logic [7:0] got [0:7];

    always_comb begin
        int idx;
        logic [7:0] b;
        idx = cpha ? ((e == 0) ? 0 : (e - 1) / 2) : e / 2;
        b = sl_byte(bi);
        miso = lsb_first ? b[idx[2:0]] : b[3'(7 - idx)];
    end

    always @(negedge clk) begin
        if (mon_clr) begin
            e = 0; bi = 0; rxi = 0; edges = 0; done_cnt = 0; ss_bad = 0;
            done_ss_ok = 1'b0;
            for (int j = 0; j < 8; j++) got[j] = '0;
        end else if (rst_n) begin
            if (sclk !== sclk_prev) begin
                int bit_i;
                edges++;
                if (ss_n[cs_sel] || !ss_lo_prev) ss_bad++;
                e++;
                if (cpha ? (e % 2 == 0) : (e % 2 == 1)) begin
                    bit_i = (e - 1) / 2;
                    if (bi < 8) got[bi][lsb_first ? bit_i : 7 - bit_i] = mosi;
                end
                if (e == 16) begin e = 0; bi++; end
            end
            for (int j = 0; j < 4; j++)
                if (j != int'(cs_sel) && !ss_n[j]) ss_bad++;
            if (rx_push) begin
                chk(rx_data == sl_byte(rxi), "R6 rx byte", rx_data, sl_byte(rxi));
                rxi++;
            end
            if (done) begin
                done_cnt++;
                done_ss_ok = (&ss_n) && ss_lo_prev && !busy;
            end
        end
        sclk_prev  = sclk;
        ss_lo_prev = !ss_n[cs_sel];
    end

    task automatic prep(input int n, input int avail);
        @(negedge clk);
        fifo_clr = 1'b1; mon_clr = 1'b1;
        for (int i = 0; i < 16; i++) tx_mem[i] = tx_byte(i);
        tx_avail = avail;
        burst_len = 16'(n);
        @(negedge clk);
        fifo_clr = 1'b0; mon_clr = 1'b0;
    endtask

    task automatic pulse_start();
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        for (int c = 0; c < lim && done_cnt == 0; c++) @(negedge clk);
    endtask

    // vector: [15]cpol [14]cpha [13]lsb [12:11]sel [10:8]nbytes [7:0]seed
    localparam logic [15:0] VEC [8] = '{
        16'b0_0_0_00_001_10100101,
        16'b0_1_0_01_010_00111100,
        16'b1_0_0_10_011_11000011,
        16'b1_1_0_11_010_01011010,
        16'b0_0_1_01_011_10011001,
        16'b0_1_1_10_001_01100110,
        16'b1_0_1_11_100_11110000,
        16'b1_1_1_00_111_00001111
    };

    initial begin
        run_en = 1'b1; master_en = 1'b1; soft_rst = 1'b0; start_wr = 1'b0;
        cpol = 1'b0; cpha = 1'b0; lsb_first = 1'b0; cs_sel = 2'd0;
        cs_sw = 1'b0; cs_level = 1'b1; burst_len = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(ss_n == 4'hF, "R1 ss_n in reset", ss_n, 4'hF);
        chk(sclk == 1'b0 && !busy && !done && !tx_pop && !rx_push, "R1 outputs in reset",
            {sclk, busy, done, tx_pop, rx_push}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int v = 0; v < 8; v++) begin
            int n;
            string tg;
            cpol = VEC[v][15]; cpha = VEC[v][14]; lsb_first = VEC[v][13];
            cs_sel = VEC[v][12:11]; n = int'(VEC[v][10:8]); cur_seed = VEC[v][7:0];
            tg = lsb_first ? "R5 mosi bits" : "R4 mosi bits";
            prep(n, n);
            chk(sclk == cpol, "R3 idle level", sclk, cpol);
            pulse_start();
            chk(busy && !ss_n[cs_sel], "R2 busy after start", {busy, ss_n[cs_sel]}, 2'b10);
            wait_done(3000);
            @(negedge clk);
            chk(edges == 16 * n, "R2 edge count", edges, 16 * n);
            chk(tx_rd == n, "R2 bytes popped", tx_rd, n);
            chk(rxi == n, "R6 bytes pushed", rxi, n);
            for (int i = 0; i < n; i++) chk(got[i] == tx_byte(i), tg, got[i], tx_byte(i));
            chk(ss_bad == 0, "R7 chip select during edges", ss_bad, 0);
            chk(done_cnt == 1 && done_ss_ok, "R10 done with ss release", done_cnt, 1);
            chk(sclk == cpol && !busy, "R3 idle after burst", sclk, cpol);
        end

        // R9 stall on empty transmit FIFO
        cpol = 1'b0; cpha = 1'b0; lsb_first = 1'b0; cs_sel = 2'd1; cur_seed = 8'h5C;
        prep(2, 1);
        pulse_start();
        repeat (200) @(negedge clk);
        chk(edges == 16 && busy && tx_rd == 1, "R9 stall while empty", edges, 16);
        tx_avail = 2;
        wait_done(3000);
        @(negedge clk);
        chk(edges == 32 && rxi == 2 && done_cnt == 1, "R9 resume after refill", edges, 32);
        chk(got[1] == tx_byte(1), "R9 second byte after stall", got[1], tx_byte(1));

        // R11 soft reset mid-burst
        prep(3, 3);
        pulse_start();
        repeat (40) @(negedge clk);
        soft_rst = 1'b1;
        @(negedge clk);
        soft_rst = 1'b0;
        chk(!busy && ss_n == 4'hF && sclk == cpol, "R11 abort to idle", {busy, ss_n}, 5'h0F);
        repeat (20) @(negedge clk);
        chk(done_cnt == 0, "R11 no done after abort", done_cnt, 0);

        // R11 enable dropped mid-burst
        prep(2, 2);
        pulse_start();
        repeat (30) @(negedge clk);
        master_en = 1'b0;
        @(negedge clk);
        master_en = 1'b1;
        chk(!busy && ss_n == 4'hF && done_cnt == 0, "R11 master drop", {busy, ss_n}, 5'h0F);

        // R2 start ignored when disabled
        run_en = 1'b0;
        prep(2, 2);
        pulse_start();
        repeat (20) @(negedge clk);
        chk(!busy && tx_rd == 0 && ss_n == 4'hF && edges == 0, "R2 start ignored", tx_rd, 0);
        run_en = 1'b1;

        // R12 zero length
        prep(0, 2);
        start_wr = 1'b1;
        @(negedge clk);
        start_wr = 1'b0;
        chk(done && !busy && ss_n == 4'hF, "R12 immediate done", {done, busy}, 2'b10);
        repeat (10) @(negedge clk);
        chk(edges == 0 && tx_rd == 0 && done_cnt == 1, "R12 no activity", edges, 0);

        // R8 software chip select
        cs_sw = 1'b1; cs_sel = 2'd2; cs_level = 1'b0;
        @(negedge clk);
        chk(ss_n == 4'b1011, "R8 sw level low", ss_n, 4'b1011);
        cs_level = 1'b1;
        prep(1, 1);
        pulse_start();
        wait_done(3000);
        chk(ss_n == 4'hF && done_cnt == 1 && edges == 16, "R8 level held during burst", ss_n, 4'hF);
        chk(ss_bad == 16, "R8 line never followed timing", ss_bad, 16);
        cs_sw = 1'b0;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=1 expected=0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule